// File: doc/BRIEF.md
# Two-Wire Slave Byte-Write Controller

This block is the receive side of a two-wire serial slave that fronts a small byte-addressed storage array. It watches the clock and data lines, finds START and STOP conditions, shifts in a device-select byte, a target address byte and a data byte, and pulls the data line low to acknowledge each of them. The write takes effect only when the master closes the transfer with STOP. Until then it is held as pending, and a repeated START throws it away.

Some array locations are marked nonvolatile by a parameter mask. A committed write to one of them starts an internal programming period of fixed length. For that whole period the block ignores the bus, never drives the data line and raises `busy_o`. A master finds out when the period has ended by polling the device-select byte until it is acknowledged. A write-enable latch gates every array write. The latch is held in a control byte at a fixed address, and that byte can always be written. When the latch is clear, array writes are still acknowledged, but their data is dropped. The array contents are available to neighbouring logic through a combinational lookup port. The lookup port, `busy_o` and `wel_o` are plain level signals. No stream interface crosses the block's edge, so there is no back-pressure.

Top module: `twr_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `busy_o` is 0, `wel_o` is 0 and every array byte reads 0.
- R2: Only the device byte {4'b1010, DEV_SEL, 1'b0} (upper nibble 1010, then the 3-bit select, then a write bit of 0) is acknowledged. Any other device byte, including one with the read bit set, is not acknowledged, and the bytes after it up to the next START are ignored.
- R3: In an accepted transfer the device byte, the address byte and the data byte are each acknowledged: `sda_oe_o` rises after the eighth SCL falling edge and falls after the ninth. A fourth byte is not acknowledged.
- R4: A write is committed only at STOP. A repeated START before STOP discards the pending write.
- R5: A write to address CTRL_ADDR (default 8'h86) always takes effect and loads the write-enable latch from data bit WEL_BIT (default 1).
- R6: While the latch is clear, an array write is acknowledged as usual, but the array stays unchanged and `busy_o` stays 0.
- R7: With the latch set, a write to an address below DEPTH whose NV_MASK bit is 0 updates the array at STOP, and `busy_o` stays 0.
- R8: With the latch set, a write to an address whose NV_MASK bit is 1 updates the array and holds `busy_o` high for exactly WR_CYCLES clock cycles.
- R9: While `busy_o` is high, `sda_oe_o` stays 0, no byte is acknowledged and no write is accepted.
- R10: A write to an address at or above DEPTH, other than CTRL_ADDR, changes neither the array nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| busy_o | output | 1 | Internal programming period in progress |
| wel_o | output | 1 | Write-enable latch state |
| rd_addr_i | input | AW | Lookup address into the array |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |

## Verification
The hardest state to reach from the ports is a new transfer that arrives while a programming period is running. A master normally waits for the period to end, and a slow bus can let the period expire before the device byte is complete. The bench lengthens WR_CYCLES well beyond one full three-byte transfer. It then issues a new START straight after the STOP that begins the period. It checks that no acknowledge appears and that the target byte keeps its old value once `busy_o` falls. The repeated-START abort is reached by inserting START in place of STOP after a fully acknowledged data byte.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK, PH_SKIP} phase_t;
  typedef enum logic [1:0] {SLOT_DEV, SLOT_ADDR, SLOT_DATA, SLOT_XTRA} slot_t;
  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } wr_req_t;
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= raw_i[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl_o[g]  = s2;
    assign rise_o[g] = s2 & ~s3;
    assign fall_o[g] = ~s2 & s3;
  end
endmodule

// File: rtl/twr_bus_fsm.sv
module twr_bus_fsm
  import twr_pkg::*;
#(
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_lvl,
  input  logic    scl_rise,
  input  logic    scl_fall,
  input  logic    sda_lvl,
  input  logic    sda_rise,
  input  logic    sda_fall,
  input  logic    busy,
  output logic    sda_oe,
  output logic    wr_stb,
  output wr_req_t wr_req
);
  localparam logic [7:0] DEV_BYTE = {4'b1010, DEV_SEL, 1'b0};
  localparam logic [3:0] LAST_BIT = 4'd8;

  phase_t     ph;
  slot_t      slot;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       pend;
  logic       take;
  logic       start_det, stop_det;

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  always_comb begin
    unique case (slot)
      SLOT_DEV:  take = (shreg == DEV_BYTE);
      SLOT_ADDR: take = 1'b1;
      SLOT_DATA: take = 1'b1;
      default:   take = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      slot   <= SLOT_DEV;
      bitcnt <= '0;
      shreg  <= '0;
      pend   <= 1'b0;
      sda_oe <= 1'b0;
      wr_stb <= 1'b0;
      wr_req <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (busy) begin
        ph     <= PH_IDLE;
        pend   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        ph     <= PH_RX;
        slot   <= SLOT_DEV;
        bitcnt <= '0;
        pend   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        wr_stb <= pend;
        pend   <= 1'b0;
        ph     <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (ph)
          PH_RX: begin
            if (scl_rise && bitcnt != LAST_BIT) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              if (take) begin
                ph     <= PH_ACK;
                sda_oe <= 1'b1;
                if (slot == SLOT_ADDR) wr_req.addr <= shreg;
                if (slot == SLOT_DATA) begin
                  wr_req.data <= shreg;
                  pend        <= 1'b1;
                end
              end else begin
                ph <= PH_SKIP;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              ph     <= PH_RX;
              slot   <= slot_t'(slot + 2'd1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: acknowledge begins only right after a falling SCL edge
  p_ack_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R4: a commit strobe only follows a STOP condition
  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(stop_det));
  // R9: data line stays released during the programming period
  p_quiet_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
endmodule

// File: rtl/twr_store.sv
module twr_store
  import twr_pkg::*;
#(
  parameter int               DEPTH     = 16,
  parameter logic [DEPTH-1:0] NV_MASK   = 16'hFF00,
  parameter int               WR_CYCLES = 64,
  parameter logic [7:0]       CTRL_ADDR = 8'h86,
  parameter int               WEL_BIT   = 1,
  localparam int              AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  wr_req_t       wr_req,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          wel
);
  localparam int         CW      = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] DEPTH_B = 8'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          in_array, is_ctrl;
  logic [AW-1:0] idx;

  assign is_ctrl  = (wr_req.addr == CTRL_ADDR);
  assign in_array = (wr_req.addr < DEPTH_B);
  assign idx      = wr_req.addr[AW-1:0];
  assign busy     = (cnt != '0);
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt <= '0;
      wel <= 1'b0;
    end else begin
      if (busy) cnt <= cnt - CW'(1);
      if (wr_stb) begin
        if (is_ctrl) begin
          wel <= wr_req.data[WEL_BIT];
        end else if (in_array && wel) begin
          mem[idx] <= wr_req.data;
          if (NV_MASK[idx]) cnt <= CW'(WR_CYCLES);
        end
      end
    end
  end

  // R8: programming timer steps down by one each cycle until it ends
  p_busy_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt == $past(cnt) - CW'(1)));
  // R6: a programming period only starts with the latch set
  p_nv_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R9: no commit arrives while programming
  p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !busy);
endmodule

// File: rtl/twr_slave.sv
module twr_slave
  import twr_pkg::*;
#(
  parameter logic [2:0]       DEV_SEL   = 3'b000,
  parameter int               DEPTH     = 16,
  parameter logic [DEPTH-1:0] NV_MASK   = 16'hFF00,
  parameter int               WR_CYCLES = 64,
  parameter logic [7:0]       CTRL_ADDR = 8'h86,
  parameter int               WEL_BIT   = 1,
  localparam int              AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          wel_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [1:0] lvl, rise, fall;
  logic       wr_stb;
  wr_req_t    wr_req;

  twr_line_sync #(.N(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({scl_i, sda_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  twr_bus_fsm #(.DEV_SEL(DEV_SEL)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (lvl[1]),
    .scl_rise (rise[1]),
    .scl_fall (fall[1]),
    .sda_lvl  (lvl[0]),
    .sda_rise (rise[0]),
    .sda_fall (fall[0]),
    .busy     (busy_o),
    .sda_oe   (sda_oe_o),
    .wr_stb   (wr_stb),
    .wr_req   (wr_req)
  );

  twr_store #(
    .DEPTH(DEPTH), .NV_MASK(NV_MASK), .WR_CYCLES(WR_CYCLES),
    .CTRL_ADDR(CTRL_ADDR), .WEL_BIT(WEL_BIT)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_req  (wr_req),
    .rd_addr (rd_addr_i),
    .rd_data (rd_data_o),
    .busy    (busy_o),
    .wel     (wel_o)
  );
endmodule

// File: tb/tb_twr_slave.sv
`timescale 1ns/1ps
module tb_twr_slave;
  localparam logic [2:0]  DSEL = 3'b101;
  localparam int          WRC  = 2000;
  localparam logic [15:0] NVM  = 16'hFF00;
  localparam logic [7:0]  DEVW = {4'b1010, DSEL, 1'b0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe, busy, wel;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  int         nchk = 0, nfail = 0;
  bit         done = 1'b0;
  logic [7:0] expm [16];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twr_slave #(.DEV_SEL(DSEL), .DEPTH(16), .NV_MASK(NVM), .WR_CYCLES(WRC),
              .CTRL_ADDR(8'h86), .WEL_BIT(1)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_o(busy), .wel_o(wel),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(6); scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    tick(8); sda_m = 1'b0; tick(6); scl_m = 1'b1; tick(8); sda_m = 1'b1;
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(8); sda_m = b[i]; tick(6); scl_m = 1'b1; tick(14); scl_m = 1'b0;
    end
    tick(8); sda_m = 1'b1; tick(6); scl_m = 1'b1; tick(7);
    ack = ~sda_line;
    tick(7); scl_m = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] dv, input logic [7:0] ad, input logic [7:0] dt,
                      output logic [2:0] acks);
    logic a;
    bus_start();
    bus_byte(dv, a); acks[2] = a;
    bus_byte(ad, a); acks[1] = a;
    bus_byte(dt, a); acks[0] = a;
  endtask

  task automatic busy_len(output int len);
    int w = 0;
    len = 0;
    while (!busy && w < 30) begin tick(1); w++; end
    while (busy && len < WRC + 100) begin tick(1); len++; end
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 4'(i); tick(1);
      chk(rd_data == expm[i], req, rd_data, expm[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic a;
    int len;
    for (int i = 0; i < 16; i++) expm[i] = '0;
    tick(5); rst_n = 1'b1; tick(5);

    // R1: reset state
    chk(sda_oe == 1'b0 && busy == 1'b0, "R1 oe/busy", {sda_oe, busy}, 0);
    chk(wel == 1'b0, "R1 wel", wel, 0);
    check_mem("R1 array");

    // R2: sweep all device bytes with the 1010 nibble plus foreign nibbles
    for (int k = 0; k < 18; k++) begin
      logic [7:0] dv;
      dv = (k < 16) ? {4'b1010, 4'(k)} : ((k == 16) ? 8'h5A : 8'hEA);
      xfer(dv, 8'h86, 8'h02, acks);
      bus_stop(); tick(20);
      if (dv == DEVW)
        chk(acks == 3'b111, "R2 match acks", acks, 7);
      else
        chk(acks == 3'b000, "R2 foreign ignored", acks, 0);
      chk(wel == (dv == DEVW), "R2 latch effect", wel, (dv == DEVW));
      if (dv == DEVW) begin
        xfer(DEVW, 8'h86, 8'h00, acks); bus_stop(); tick(20);
      end
    end

    // R6: latch clear, acked but dropped
    xfer(DEVW, 8'h09, 8'h77, acks);
    chk(acks == 3'b111, "R6 acks with latch clear", acks, 7);
    bus_stop(); busy_len(len);
    chk(len == 0, "R6 no busy", len, 0);
    check_mem("R6 array unchanged");

    // R5: set latch through control byte
    xfer(DEVW, 8'h86, 8'h02, acks); bus_stop(); tick(20);
    chk(acks == 3'b111 && wel == 1'b1, "R5 latch set", {acks, wel}, 15);

    // R7 / R8: every array address
    for (int ad = 0; ad < 16; ad++) begin
      logic [7:0] dt;
      dt = 8'(ad * 17 + 3);
      xfer(DEVW, 8'(ad), dt, acks);
      chk(acks == 3'b111, "R3 three acks", acks, 7);
      if (ad == 5) begin
        bus_byte(8'hC3, a);
        chk(a == 1'b0, "R3 fourth byte nack", a, 0);
      end
      bus_stop(); busy_len(len);
      expm[ad] = dt;
      if (NVM[ad]) chk(len == WRC, "R8 busy length", len, WRC);
      else         chk(len == 0, "R7 volatile no busy", len, 0);
      rd_addr = 4'(ad); tick(1);
      chk(rd_data == dt, NVM[ad] ? "R8 data" : "R7 data", rd_data, dt);
    end

    // R4: repeated START aborts pending write
    xfer(DEVW, 8'h03, 8'hEE, acks);
    bus_start(); bus_stop(); busy_len(len);
    chk(len == 0, "R4 no busy after abort", len, 0);
    check_mem("R4 abort keeps array");

    // R9: transfer issued during programming period
    xfer(DEVW, 8'h0C, 8'h5C, acks); bus_stop();
    expm[12] = 8'h5C;
    tick(12);
    chk(busy == 1'b1, "R9 busy raised", busy, 1);
    xfer(DEVW, 8'h0D, 8'hA1, acks); bus_stop();
    chk(acks == 3'b000, "R9 no ack while busy", acks, 0);
    busy_len(len);
    tick(10);
    check_mem("R9 write dropped");

    // R10: out-of-range address, then control clear
    xfer(DEVW, 8'h40, 8'h99, acks); bus_stop(); busy_len(len);
    chk(len == 0 && wel == 1'b1, "R10 no effect", {len[3:0], wel}, 1);
    check_mem("R10 array");
    xfer(DEVW, 8'h86, 8'hFD, acks); bus_stop(); tick(20);
    chk(wel == 1'b0, "R5 latch cleared", wel, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule